// File: doc/BRIEF.md
# Instruction-Cache Data RAM Test Sequencer

This block puts an instruction-cache data array under direct control of an external tester. The tester holds an enable high for the whole test. It then streams accesses, one per two-cycle pair. Each pair starts with a write cycle, in which the strobe is low. In that cycle the word address and the write data are applied and the word is stored. The pair ends with a read cycle, in which the strobe is high. In that cycle the array is read at the address present. The strobe therefore toggles every cycle in steady state.

Accesses overlap. The word read in one pair is presented on the read-back bus during the read cycle of the next pair, two cycles after its array read. This gives the tester a fixed slot in which to compare it. The address port carries word-address bits 14 down to 2. Only the low eleven of those bits (byte-address bits 12..2) index the 2048-word array.

The stream has a fixed rhythm and no back-pressure, so the tester pins are plain levels rather than a valid/ready pair. Dropping the enable flushes any read-back still in flight.

Top module: `icram_test_seq`

## Requirements
- R1: While reset is asserted and after it is released, `rb_data` is zero until the first read-back is delivered.
- R2: A cycle with `tst_en`=1 and `tst_stb`=0 is a write cycle. At the clock edge that ends it, `tst_wdat` is stored at array index `tst_addr[10:0]`.
- R3: A cycle with `tst_en`=1 and `tst_stb`=1 that directly follows a write cycle is a read cycle. It reads the array at the `tst_addr` present in that cycle, and it sees the word written in the previous cycle.
- R4: The word read in a read cycle appears on `rb_data` two cycles later: from the start of the read cycle of the following pair.
- R5: `rb_data` holds its value in every cycle that does not deliver a new read-back.
- R6: `tst_addr[12:11]` (byte-address bits 14..13) have no effect. Two addresses that differ only there reach the same array word.
- R7: While `tst_en`=0, nothing is written to the array, any read-back still in flight is discarded, and `rb_data` holds.
- R8: A strobe-high cycle that does not directly follow a write cycle performs no read and leads to no `rb_data` update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tst_en | input | 1 | Test enable, held high for the whole sequence |
| tst_stb | input | 1 | Phase strobe: low selects a write cycle, high selects a read cycle |
| tst_addr | input | 13 | Word address, byte-address bits 14..2 |
| tst_wdat | input | 32 | Write data, valid in the write cycle |
| rb_data | output | 32 | Read-back word, two cycles after its array read |

## Verification
The bench reuses one address with different data. A design whose read cycle returned the array contents from before the write would hand back the stale word. It also samples `rb_data` in both halves of each pair, which catches an output register that is one cycle early or late. Writes are attempted while disabled, and a later read-back proves they did not land. The enable is dropped straight after a read cycle, so a pipeline that ignored the flush would deliver that word. Extra strobe-high cycles, and an address changed between write and read, show whether spurious reads happen and whether the two upper address bits alias correctly.

// File: rtl/icram_pkg.sv
package icram_pkg;
  // word address as seen on the tester port: byte-address bits 14..2
  localparam int unsigned TST_ADDR_W = 13;
  // array index width: byte-address bits 12..2
  localparam int unsigned TST_IDX_W  = 11;
  localparam int unsigned TST_DATA_W = 32;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } tst_phase_e;
endpackage

// File: rtl/icram_phase_dec.sv
module icram_phase_dec
  import icram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stb,
  output logic we,
  output logic re,
  output tst_phase_e phase
);
  // remembers that the previous cycle was a write cycle
  logic wr_prev;

  always_comb begin
    we    = en & ~stb;
    re    = en & stb & wr_prev;
    phase = we ? PH_WRITE : (re ? PH_READ : PH_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev <= 1'b0;
    else        wr_prev <= we;
  end
endmodule

// File: rtl/icram_data_array.sv
module icram_data_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata    <= mem[idx];
  end
endmodule

// File: rtl/icram_rb_pipe.sv
module icram_rb_pipe #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              re,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] rb
);
  // an array read finished at the last edge; its word waits in rdata
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      rb   <= '0;
    end else if (!en) begin
      pend <= 1'b0;
    end else begin
      pend <= re;
      if (pend) rb <= rdata;
    end
  end
endmodule

// File: rtl/icram_test_seq.sv
module icram_test_seq
  import icram_pkg::*;
#(
  parameter int unsigned ADDR_W = TST_ADDR_W,
  parameter int unsigned IDX_W  = TST_IDX_W,
  parameter int unsigned DATA_W = TST_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tst_en,
  input  logic              tst_stb,
  input  logic [ADDR_W-1:0] tst_addr,
  input  logic [DATA_W-1:0] tst_wdat,
  output logic [DATA_W-1:0] rb_data
);
  localparam int unsigned HI_W = ADDR_W - IDX_W;

  logic              mem_we;
  logic              mem_re;
  tst_phase_e        phase;
  logic [IDX_W-1:0]  arr_idx;
  logic [DATA_W-1:0] arr_rdata;

  assign arr_idx = tst_addr[IDX_W-1:0];

  generate
    if (HI_W > 0) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^{tst_addr[ADDR_W-1:IDX_W], phase};
    end else begin : g_nohi
      logic unused_ph;
      assign unused_ph = ^phase;
    end
  endgenerate

  icram_phase_dec u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (tst_en),
    .stb   (tst_stb),
    .we    (mem_we),
    .re    (mem_re),
    .phase (phase)
  );

  icram_data_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_arr (
    .clk   (clk),
    .we    (mem_we),
    .re    (mem_re),
    .idx   (arr_idx),
    .wdata (tst_wdat),
    .rdata (arr_rdata)
  );

  icram_rb_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (tst_en),
    .re    (mem_re),
    .rdata (arr_rdata),
    .rb    (rb_data)
  );
endmodule

// File: rtl/icram_test_seq_chk.sv
module icram_test_seq_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              we,
  input logic              re,
  input logic [DATA_W-1:0] rb
);
  // R1: output is cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (rb == '0);
    end
  end

  // R8: an array read only ever follows a write cycle
  a_r8_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    re |-> $past(we));

  // R4: the output changes only two cycles after an array read
  a_r4_update_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rb) |-> $past(re, 2));

  // R5: without a read two cycles back the output holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(re, 2) |-> $stable(rb));

  // R7: a disabled cycle neither writes nor lets the output move
  a_r7_no_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !we);

  a_r7_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rb));
endmodule

bind icram_test_seq icram_test_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (tst_en),
  .we    (mem_we),
  .re    (mem_re),
  .rb    (rb_data)
);

// File: tb/icram_test_seq_bench.sv
module icram_test_seq_bench;
  localparam int NV = 8;
  localparam logic [12:0] V_ADDR [NV] = '{
    13'h0005, 13'h07FF, 13'h0000, 13'h0005,
    13'h0123, 13'h0456, 13'h0005, 13'h0400};
  localparam logic [31:0] V_DATA [NV] = '{
    32'h1111_0001, 32'hFFFF_0002, 32'h0000_0003, 32'hA5A5_0004,
    32'h1234_5678, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h8000_0001};
  // expected read-back in each read cycle: the previous access's word
  localparam logic [31:0] V_EXP [NV] = '{
    32'h0,         32'h1111_0001, 32'hFFFF_0002, 32'h0000_0003,
    32'hA5A5_0004, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0BAD_F00D};

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        en = 1'b0;
  logic        stb = 1'b1;
  logic [12:0] addr = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rb;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  icram_test_seq u_icram_test_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tst_en   (en),
    .tst_stb  (stb),
    .tst_addr (addr),
    .tst_wdat (wdat),
    .rb_data  (rb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // write cycle at wa, then read cycle at ra; ends inside the read cycle
  task automatic pair(input logic [12:0] wa, input logic [31:0] d, input logic [12:0] ra);
    @(negedge clk); en = 1'b1; stb = 1'b0; addr = wa; wdat = d;
    @(negedge clk); stb = 1'b1; addr = ra;
  endtask

  // strobe-high cycle with no write before it, then settle on the next cycle
  task automatic drain();
    @(negedge clk); en = 1'b1; stb = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", rb, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", rb, 32'h0);

    // R2 R3 R4 R5: steady stream, sampled in both halves of every pair
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); en = 1'b1; stb = 1'b0; addr = V_ADDR[i]; wdat = V_DATA[i];
      chk("R5 write-cycle hold", rb, (i == 0) ? 32'h0 : V_EXP[i-1]);
      @(negedge clk); stb = 1'b1;
      chk("R4 read-back slot", rb, V_EXP[i]);
    end
    // R8: extra strobe-high cycle delivers the last word but reads nothing new
    drain();
    chk("R4 last read-back", rb, V_DATA[NV-1]);
    repeat (3) @(negedge clk);
    chk("R8 no spurious update", rb, V_DATA[NV-1]);

    // R6: written with upper bits 11, read back through upper bits 00
    pair(13'h1923, 32'hCAFE_0001, 13'h1923);
    pair(13'h0200, 32'h5555_AAAA, 13'h0123);
    drain();
    chk("R6 upper bits ignored", rb, 32'hCAFE_0001);

    // R3: read cycle uses its own address
    pair(13'h0300, 32'h7777_0000, 13'h0200);
    drain();
    chk("R3 read address", rb, 32'h5555_AAAA);

    // R7: writes attempted while disabled must not land
    pair(13'h0040, 32'h0F0F_0040, 13'h0040);
    drain();
    chk("R2 store", rb, 32'h0F0F_0040);
    @(negedge clk); en = 1'b0; stb = 1'b0; addr = 13'h0040; wdat = 32'hBADB_AD00;
    @(negedge clk); stb = 1'b1;
    @(negedge clk); stb = 1'b0; wdat = 32'hBADB_AD01;
    @(negedge clk);
    pair(13'h0041, 32'h0000_0041, 13'h0040);
    drain();
    chk("R7 no write while off", rb, 32'h0F0F_0040);

    // R7: enable dropped right after a read cycle flushes its read-back
    pair(13'h0050, 32'h5050_5050, 13'h0050);
    @(negedge clk); en = 1'b0; stb = 1'b0;
    @(negedge clk);
    chk("R7 flush hold", rb, 32'h0F0F_0040);
    @(negedge clk); en = 1'b1; stb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 no read after flush", rb, 32'h0F0F_0040);

    // resumes normally after the flush
    pair(13'h0060, 32'h6060_6060, 13'h0060);
    drain();
    chk("R4 after flush", rb, 32'h6060_6060);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule